// File: doc/BRIEF.md
# Rectangle Blitter with Transparency

This block copies a rectangle of 8-bit pixels from a source graphics memory into a 128x128 byte-per-pixel framebuffer, one pixel per clock. The host only presents the rectangle description on the configuration inputs and pulses `start`. The block captures the description, walks the rectangle row by row, and reads from the source memory while it writes the framebuffer. The host is free for other work while the copy runs.

The source memory is addressed by an 8-bit column and an 8-bit row, and its read port returns data one clock after the request. The write stage is delayed to match that read latency, so the copy keeps its rate of one pixel per clock. Two options change how pixels move. Transparency drops framebuffer writes of zero-valued pixels. Per-axis mirroring inverts the bits of the source coordinate but keeps the walk order. Destination coordinates wrap modulo 128, so the rectangle may be drawn into any of the 128 rows, including those that are not visible. At the end, `done` pulses for one cycle and serves as an interrupt.

Top module: `rect_blit`

## Requirements
- R1: A `start` seen on a clock edge while `busy` is low captures all configuration inputs. For a rectangle of N = width*height > 0 pixels, `busy` is then high for exactly N+1 cycles, beginning in the cycle after that edge.
- R2: Pixel k (k = 0..N-1, row-major, column offset k mod width, row offset k div width) is requested in cycle k+1 after the start edge, with `src_rd_en` high and `src_addr` = {row[7:0], column[7:0]}. The column is (src_x + offset) mod 256 and the row is (src_y + offset) mod 256.
- R3: Pixel k is written in cycle k+2 with `fb_wdata` equal to the byte returned by the source memory and `fb_addr` = {dst_row[6:0], dst_col[6:0]}, where dst_col = (dst_x + column offset) mod 128 and dst_row = (dst_y + row offset) mod 128.
- R4: When transparency is enabled, a source byte of 0 produces no write (`fb_we` low in that cycle) and the walk still advances. When it is disabled, zero bytes are written like any other value.
- R5: Mirroring X (or Y) replaces the source column (or row) by its bitwise inverse. The walk order and destination addresses are unchanged.
- R6: A rectangle whose starting source and destination X both have low nibble 1111 is copied correctly: the first column, the carry into the next nibble, and each return to the start column at the end of a row.
- R7: `done` is high for exactly one cycle, the cycle after the last write (cycle N+2). `busy` is low in that cycle.
- R8: A `start` while `busy` is high has no effect. Changes to the configuration inputs during a copy have no effect either.
- R9: A width or height of zero produces no reads and no writes, keeps `busy` low, and pulses `done` in the cycle after the start edge.
- R10: While reset (`rst_n` low) is held, `busy`, `done`, `src_rd_en` and `fb_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, honoured only while idle |
| cfg_src_x | input | 8 | Source start column |
| cfg_src_y | input | 8 | Source start row |
| cfg_dst_x | input | 7 | Framebuffer start column |
| cfg_dst_y | input | 7 | Framebuffer start row |
| cfg_width | input | 8 | Rectangle width in pixels |
| cfg_height | input | 8 | Rectangle height in pixels |
| cfg_transp | input | 1 | Skip writes of zero pixels |
| cfg_flip_x | input | 1 | Invert source column bits |
| cfg_flip_y | input | 1 | Invert source row bits |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse / interrupt |
| src_rd_en | output | 1 | Source memory read request |
| src_addr | output | 16 | Source address {row, column} |
| src_rd_data | input | 8 | Source data, valid one cycle after the request |
| fb_we | output | 1 | Framebuffer write enable |
| fb_addr | output | 14 | Framebuffer address {row, column} |
| fb_wdata | output | 8 | Framebuffer write data |

## Verification
On every cycle, the assertions check that the column counter stays inside the captured width, that the captured configuration holds while a restart is refused, that `done` never lasts two cycles and never coincides with `busy`, that reads occur only while busy, and that every write follows a read in the previous cycle. Only the bench scenarios show that the addresses follow the row-major order with correct wrapping, mirroring and nibble-carry starts. They also show that transparent pixels are dropped but zero pixels are kept when transparency is off, and that empty rectangles still signal completion. To show this, a behavioural model predicts each cycle's outputs.

// File: rtl/rblit_pkg.sv
package rblit_pkg;
  localparam int SRC_CW = 8;   // source coordinate width per axis
  localparam int DST_CW = 7;   // framebuffer coordinate width per axis
  localparam int EXT_W  = 8;   // rectangle extent width
  localparam int PIX_W  = 8;   // pixel width
  localparam int SRC_AW = 2 * SRC_CW;
  localparam int DST_AW = 2 * DST_CW;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_RUN   = 2'd1,
    WK_DRAIN = 2'd2
  } walk_state_e;

  // mirrored coordinate: bitwise inverse, counting order untouched
  function automatic logic [SRC_CW-1:0] mirror_coord(input logic [SRC_CW-1:0] c,
                                                      input logic en);
    return en ? ~c : c;
  endfunction

  // pixel suppressed when transparency is on and the byte is zero
  function automatic logic pixel_clear(input logic [PIX_W-1:0] p, input logic en);
    return en && (p == '0);
  endfunction

  function automatic logic extent_empty(input logic [EXT_W-1:0] w,
                                        input logic [EXT_W-1:0] h);
    return (w == '0) || (h == '0);
  endfunction
endpackage

// File: rtl/rblit_walk.sv
module rblit_walk
  import rblit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SRC_CW-1:0] sx,
  input  logic [SRC_CW-1:0] sy,
  input  logic [DST_CW-1:0] dx,
  input  logic [DST_CW-1:0] dy,
  input  logic [EXT_W-1:0]  wd,
  input  logic [EXT_W-1:0]  ht,
  input  logic              transp,
  input  logic              flip_x,
  input  logic              flip_y,
  output logic              busy,
  output logic              done,
  output logic              rd_en,
  output logic [SRC_CW-1:0] rd_x,
  output logic [SRC_CW-1:0] rd_y,
  output logic [DST_CW-1:0] wr_x,
  output logic [DST_CW-1:0] wr_y,
  output logic              transp_o
);
  localparam logic [EXT_W-1:0] EXT_ONE = EXT_W'(1);

  walk_state_e       st_q;
  logic [SRC_CW-1:0] sx_lat, sy_lat, sx_cur, sy_cur;
  logic [DST_CW-1:0] dx_lat, dx_cur, dy_cur;
  logic [EXT_W-1:0]  w_lat, h_lat, col_q, row_q;
  logic              tr_lat, fx_lat, fy_lat, done_q;

  // named internal events
  logic start_ok, row_end, last_px;
  assign start_ok = start && (st_q == WK_IDLE);
  assign row_end  = (st_q == WK_RUN) && (col_q == w_lat - EXT_ONE);
  assign last_px  = row_end && (row_q == h_lat - EXT_ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      done_q <= 1'b0;
      sx_lat <= '0; sy_lat <= '0; dx_lat <= '0;
      sx_cur <= '0; sy_cur <= '0; dx_cur <= '0; dy_cur <= '0;
      w_lat  <= '0; h_lat  <= '0; col_q  <= '0; row_q  <= '0;
      tr_lat <= 1'b0; fx_lat <= 1'b0; fy_lat <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        WK_IDLE: if (start_ok) begin
          sx_lat <= sx; sy_lat <= sy; dx_lat <= dx;
          sx_cur <= sx; sy_cur <= sy; dx_cur <= dx; dy_cur <= dy;
          w_lat  <= wd; h_lat  <= ht;
          tr_lat <= transp; fx_lat <= flip_x; fy_lat <= flip_y;
          col_q  <= '0; row_q <= '0;
          if (extent_empty(wd, ht)) done_q <= 1'b1;
          else                      st_q   <= WK_RUN;
        end
        WK_RUN: begin
          if (last_px) begin
            st_q <= WK_DRAIN;
          end else if (row_end) begin
            col_q  <= '0;
            sx_cur <= sx_lat;
            dx_cur <= dx_lat;
            row_q  <= row_q + EXT_ONE;
            sy_cur <= sy_cur + SRC_CW'(1);
            dy_cur <= dy_cur + DST_CW'(1);
          end else begin
            col_q  <= col_q + EXT_ONE;
            sx_cur <= sx_cur + SRC_CW'(1);
            dx_cur <= dx_cur + DST_CW'(1);
          end
        end
        WK_DRAIN: begin
          st_q   <= WK_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  assign busy     = (st_q != WK_IDLE);
  assign done     = done_q;
  assign rd_en    = (st_q == WK_RUN);
  assign rd_x     = mirror_coord(sx_cur, fx_lat);
  assign rd_y     = mirror_coord(sy_cur, fy_lat);
  assign wr_x     = dx_cur;
  assign wr_y     = dy_cur;
  assign transp_o = tr_lat;

  // R2: column counter never leaves the captured width while walking
  a_r2_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WK_RUN) |-> (col_q < w_lat));

  // R8: a refused start leaves the captured rectangle untouched
  a_r8_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(w_lat) && $stable(h_lat) && $stable(sx_lat) && $stable(dx_lat)));

  // R7: completion pulse lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: done and busy never overlap
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/rblit_wstage.sv
module rblit_wstage
  import rblit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [DST_CW-1:0] wr_x,
  input  logic [DST_CW-1:0] wr_y,
  input  logic              transp,
  input  logic [PIX_W-1:0]  rd_data,
  output logic              fb_we,
  output logic [DST_AW-1:0] fb_addr,
  output logic [PIX_W-1:0]  fb_wdata
);
  logic              vld_q, tr_q;
  logic [DST_CW-1:0] x_q, y_q;
  logic              skip_ev;

  // destination and valid delayed by the source read latency
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tr_q  <= 1'b0;
      x_q   <= '0;
      y_q   <= '0;
    end else begin
      vld_q <= rd_en;
      tr_q  <= transp;
      x_q   <= wr_x;
      y_q   <= wr_y;
    end
  end

  assign skip_ev  = vld_q && pixel_clear(rd_data, tr_q);
  assign fb_we    = vld_q && !skip_ev;
  assign fb_addr  = {y_q, x_q};
  assign fb_wdata = rd_data;

  // R3: every write is the answer to a read issued one cycle earlier
  a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> $past(rd_en));
endmodule

// File: rtl/rect_blit.sv
module rect_blit
  import rblit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SRC_CW-1:0] cfg_src_x,
  input  logic [SRC_CW-1:0] cfg_src_y,
  input  logic [DST_CW-1:0] cfg_dst_x,
  input  logic [DST_CW-1:0] cfg_dst_y,
  input  logic [EXT_W-1:0]  cfg_width,
  input  logic [EXT_W-1:0]  cfg_height,
  input  logic              cfg_transp,
  input  logic              cfg_flip_x,
  input  logic              cfg_flip_y,
  output logic              busy,
  output logic              done,
  output logic              src_rd_en,
  output logic [SRC_AW-1:0] src_addr,
  input  logic [PIX_W-1:0]  src_rd_data,
  output logic              fb_we,
  output logic [DST_AW-1:0] fb_addr,
  output logic [PIX_W-1:0]  fb_wdata
);
  logic [SRC_CW-1:0] rd_x, rd_y;
  logic [DST_CW-1:0] wr_x, wr_y;
  logic              tr_w;

  rblit_walk u_walk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .sx(cfg_src_x), .sy(cfg_src_y), .dx(cfg_dst_x), .dy(cfg_dst_y),
    .wd(cfg_width), .ht(cfg_height),
    .transp(cfg_transp), .flip_x(cfg_flip_x), .flip_y(cfg_flip_y),
    .busy(busy), .done(done), .rd_en(src_rd_en),
    .rd_x(rd_x), .rd_y(rd_y), .wr_x(wr_x), .wr_y(wr_y), .transp_o(tr_w)
  );

  assign src_addr = {rd_y, rd_x};

  rblit_wstage u_wstage (
    .clk(clk), .rst_n(rst_n), .rd_en(src_rd_en),
    .wr_x(wr_x), .wr_y(wr_y), .transp(tr_w), .rd_data(src_rd_data),
    .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata)
  );

  // R1: source reads only occur during a copy
  a_r1_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd_en |-> busy);
endmodule

// File: tb/rect_blit_bench.sv
module rect_blit_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        rst_n, start, transp, fx, fy;
  logic [7:0]  sx, sy, w, h, rd_data;
  logic [6:0]  dx, dy;
  logic        busy, done, src_rd_en, fb_we;
  logic [15:0] src_addr;
  logic [13:0] fb_addr;
  logic [7:0]  fb_wdata;
  int vec = 0, bad = 0;
  bit finished = 0;

  rect_blit u_rect_blit (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src_x(sx), .cfg_src_y(sy), .cfg_dst_x(dx), .cfg_dst_y(dy),
    .cfg_width(w), .cfg_height(h), .cfg_transp(transp),
    .cfg_flip_x(fx), .cfg_flip_y(fy),
    .busy(busy), .done(done), .src_rd_en(src_rd_en), .src_addr(src_addr),
    .src_rd_data(rd_data), .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata)
  );

  // source picture: zero on every fifth diagonal, otherwise nonzero
  function automatic logic [7:0] pat(input int x, input int y);
    if (((x + y) % 5) == 0) return 8'h00;
    return 8'((x ^ (y * 2)) | 'h40);
  endfunction

  // synchronous source memory, one cycle read latency
  always @(posedge clk) if (src_rd_en) rd_data <= pat(int'(src_addr[7:0]), int'(src_addr[15:8]));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // runs one rectangle and compares every cycle against the model
  task automatic run_job(input int jsx, input int jsy, input int jdx, input int jdy,
                         input int jw, input int jh, input bit jt, input bit jfx,
                         input bit jfy, input int poke_t);
    int n, tmax;
    n = jw * jh;
    tmax = (n == 0) ? 2 : n + 2;
    @(negedge clk);
    sx = 8'(jsx); sy = 8'(jsy); dx = 7'(jdx); dy = 7'(jdy);
    w = 8'(jw); h = 8'(jh); transp = jt; fx = jfx; fy = jfy; start = 1'b1;
    for (int t = 1; t <= tmax; t++) begin
      @(negedge clk);
      begin
        bit eb, ed, er, ew;
        int ax, ay, ox, oy, k, px;
        eb = (n > 0) && (t <= n + 1);
        ed = (n == 0) ? (t == 1) : (t == n + 2);
        chk(busy == eb, "R1", "busy", int'(busy), int'(eb));
        chk(done == ed, (n == 0) ? "R9" : "R7", "done", int'(done), int'(ed));
        er = (n > 0) && (t <= n);
        chk(src_rd_en == er, "R2", "read enable", int'(src_rd_en), int'(er));
        if (er) begin
          k = t - 1; ox = k % jw; oy = k / jw;
          ax = (jsx + ox) & 255; ay = (jsy + oy) & 255;
          if (jfx) ax = ax ^ 255;   // R5 mirror column
          if (jfy) ay = ay ^ 255;   // R5 mirror row
          chk(src_addr == 16'((ay << 8) | ax), "R2", "source address",
              int'(src_addr), (ay << 8) | ax);
        end
        ew = 1'b0;
        px = 0;
        if ((n > 0) && (t >= 2) && (t <= n + 1)) begin
          k = t - 2; ox = k % jw; oy = k / jw;
          ax = (jsx + ox) & 255; ay = (jsy + oy) & 255;
          if (jfx) ax = ax ^ 255;
          if (jfy) ay = ay ^ 255;
          px = int'(pat(ax, ay));
          ew = !(jt && (px == 0));
          if (ew) begin
            int ex, ey;
            ex = (jdx + ox) & 127; ey = (jdy + oy) & 127;
            chk(fb_addr == 14'((ey << 7) | ex), "R3", "write address",
                int'(fb_addr), (ey << 7) | ex);
            chk(fb_wdata == 8'(px), "R3", "write data", int'(fb_wdata), px);
          end
        end
        chk(fb_we == ew, "R4", "write enable", int'(fb_we), int'(ew));
      end
      // R8: refused restart with different configuration mid-copy
      if (t == poke_t) begin
        start = 1'b1; sx = 8'h99; dx = 7'h33; w = 8'd1; h = 8'd1; fx = ~fx;
      end else begin
        start = 1'b0;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; sx = '0; sy = '0; dx = '0; dy = '0;
    w = '0; h = '0; transp = 1'b0; fx = 1'b0; fy = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy, "R10", "busy in reset", int'(busy), 0);
    chk(!done, "R10", "done in reset", int'(done), 0);
    chk(!src_rd_en, "R10", "read in reset", int'(src_rd_en), 0);
    chk(!fb_we, "R10", "write in reset", int'(fb_we), 0);
    rst_n = 1'b1;
    run_job(2, 5, 10, 20, 4, 3, 1'b0, 1'b0, 1'b0, 0);  // R1 R2 R3 plain copy, zeros written (R4 off)
    run_job(0, 0, 40, 40, 6, 4, 1'b1, 1'b0, 1'b0, 0);  // R4 transparency skips zeros
    run_job(8, 3, 60, 9, 5, 3, 1'b0, 1'b1, 1'b1, 0);   // R5 both mirrors
    run_job(30, 1, 0, 0, 3, 2, 1'b1, 1'b1, 1'b0, 0);   // R5 column mirror only
    run_job(31, 7, 15, 2, 5, 3, 1'b0, 1'b0, 1'b0, 0);  // R6 low nibble 1111 start
    run_job(15, 0, 127, 126, 3, 4, 1'b1, 1'b0, 1'b0, 0); // R3 R6 wrap of both axes
    run_job(4, 4, 50, 50, 4, 4, 1'b0, 1'b0, 1'b0, 3);  // R8 start ignored while busy
    run_job(4, 4, 50, 50, 0, 5, 1'b0, 1'b0, 1'b0, 0);  // R9 zero width
    run_job(4, 4, 50, 50, 5, 0, 1'b1, 1'b0, 1'b0, 0);  // R9 zero height
    run_job(200, 250, 100, 100, 1, 1, 1'b0, 1'b0, 1'b1, 0); // R7 single pixel
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!finished) begin
      bad++;
      $display("FAIL R1 watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule